// File: doc/BRIEF.md
# Dual-Select Half-Word Static Memory Model

This block is a clock-sampled model of an asynchronous 32-bit static memory. It is meant for FPGA prototypes and simulation. It has two chip selects of opposite polarity: `sel_n` is active low and `sel` is active high. It also has an active-low write strobe, an active-low output gate, and one active-low enable for each 16-bit half of the word. The bidirectional data pins are split into an input word, an output word, and an output-enable pair with one bit per half. The pad ring turns these into tri-state buffers.

All controls are sampled on a fast internal clock. Each sample is decoded as idle, read or write. A read drives only the halves whose enables are low, and only while the output gate is low. A write stores nothing until the write condition ends. That happens when the strobe rises or when either chip select drops. The store then uses the address, data and half enables sampled in the last cycle of the write. Each half is kept in its own array, so a block RAM can be inferred for each one. The full device has 17 address bits. The default depth is smaller so that simulation stays light.

Top module: `hwsram_top`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `doe` is 00 and `dout` is all zeros.
- R2: The chip counts as selected only when `sel_n`=0 and `sel`=1. A selected sample with `we_n`=1, `oe_n`=0 and `hen_n`=00 gives `doe`=11 and `dout` equal to the stored word, one cycle later.
- R3: During a read, `dout` follows a new address in every cycle, with one cycle of latency.
- R4: A write that ends because `we_n` rises stores the address, data and half enables sampled in the last cycle in which the write was active. Inputs in the ending cycle are ignored.
- R5: A write that ends because `sel_n` rises, or because `sel` falls, stores in the same way as R4.
- R6: `oe_n` has no effect on a write. The store happens with `oe_n` high or low, and `doe` is 00 while the write is active.
- R7: `doe` is 00 one cycle after any sample with `oe_n`=1 or `we_n`=0.
- R8: `hen_n[1]` controls bits 31:16 and `hen_n[0]` controls bits 15:0. A half whose enable is high is not driven on reads: its `doe` bit is 0 and its `dout` bits are zero. That half is also not changed by writes.
- R9: With `hen_n`=11, nothing is driven and a write leaves the word unchanged.
- R10: An unselected chip drives nothing and stores nothing, even with `we_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low chip select |
| sel | input | 1 | Active-high chip select |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output gate |
| hen_n | input | 2 | Active-low half enables; bit 1 is the upper half, bit 0 the lower half |
| addr | input | ADDR_W | Word address |
| din | input | 32 | Data from the pins |
| dout | output | 32 | Data to the pins |
| doe | output | 2 | Per-half pin drive enable; bit 1 drives 31:16, bit 0 drives 15:0 |

## Verification
Read results (`doe` and `dout`) are due one clock after the controls are sampled. The bench drives inputs on the falling edge and compares at the next falling edge, so exactly one rising edge falls between stimulus and check. A write is stored on the first rising edge that sees the write condition false. Every read-back is therefore issued only after that edge, and it is checked one cycle later in turn. Blocked writes are checked by reading the word back through the normal read path.

// File: rtl/hwsram_pkg.sv
package hwsram_pkg;
  localparam int HALF_W = 16;
  localparam int N_HALF = 2;
  localparam int WORD_W = HALF_W * N_HALF;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  function automatic op_e decode_op(input logic sel_n, input logic sel,
                                    input logic we_n);
    if (sel_n || !sel) return OP_IDLE;
    return we_n ? OP_READ : OP_WRITE;
  endfunction
endpackage

// File: rtl/hwsram_ctrl.sv
module hwsram_ctrl
  import hwsram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              sel,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [N_HALF-1:0] hen_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] din,
  output logic [N_HALF-1:0] wr_commit,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic [N_HALF-1:0] rd_drive
);
  op_e               op_now;
  logic              wr_q;
  logic [N_HALF-1:0] hen_q;

  assign op_now = decode_op(sel_n, sel, we_n);

  // control state, reset
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q     <= 1'b0;
      rd_drive <= '0;
    end else begin
      wr_q <= (op_now == OP_WRITE);
      for (int h = 0; h < N_HALF; h++)
        rd_drive[h] <= (op_now == OP_READ) && !oe_n && !hen_n[h];
    end
  end

  // last-cycle write capture, no reset needed
  always_ff @(posedge clk) begin
    wr_addr <= addr;
    wr_data <= din;
    hen_q   <= hen_n;
  end

  // end of write: active last cycle, inactive now
  always_comb begin
    for (int h = 0; h < N_HALF; h++)
      wr_commit[h] = wr_q && (op_now != OP_WRITE) && !hen_q[h];
  end
endmodule

// File: rtl/hwsram_bank.sv
module hwsram_bank #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/hwsram_top.sv
module hwsram_top
  import hwsram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              sel,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [1:0]        hen_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       din,
  output logic [31:0]       dout,
  output logic [1:0]        doe
);
  logic [N_HALF-1:0] wr_commit;
  logic [ADDR_W-1:0] wr_addr;
  logic [WORD_W-1:0] wr_data;
  logic [WORD_W-1:0] rd_word;

  hwsram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .sel_n(sel_n), .sel(sel), .we_n(we_n),
    .oe_n(oe_n), .hen_n(hen_n), .addr(addr), .din(din),
    .wr_commit(wr_commit), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_drive(doe)
  );

  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    hwsram_bank #(.ADDR_W(ADDR_W), .DATA_W(HALF_W)) u_bank (
      .clk  (clk),
      .we   (wr_commit[h]),
      .waddr(wr_addr),
      .wdata(wr_data[h*HALF_W +: HALF_W]),
      .raddr(addr),
      .rdata(rd_word[h*HALF_W +: HALF_W])
    );
    assign dout[h*HALF_W +: HALF_W] = doe[h] ? rd_word[h*HALF_W +: HALF_W] : '0;
  end
endmodule

// File: rtl/hwsram_chk.sv
module hwsram_chk (
  input logic        clk,
  input logic        rst,
  input logic        sel_n,
  input logic        sel,
  input logic        we_n,
  input logic        oe_n,
  input logic [1:0]  hen_n,
  input logic [31:0] dout,
  input logic [1:0]  doe
);
  logic rd_sel;
  assign rd_sel = !sel_n && sel && we_n && !oe_n;

  // R1
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (doe == 2'b00 && dout == 32'h0));
  // R2
  a_r2_full_read: assert property (@(posedge clk) disable iff (rst)
    (rd_sel && hen_n == 2'b00) |=> (doe == 2'b11));
  // R7
  a_r7_hiz: assert property (@(posedge clk) disable iff (rst)
    (oe_n || !we_n) |=> (doe == 2'b00));
  // R8
  a_r8_upper_only: assert property (@(posedge clk) disable iff (rst)
    (rd_sel && hen_n == 2'b01) |=> (doe == 2'b10 && dout[15:0] == 16'h0));
  // R9
  a_r9_no_half: assert property (@(posedge clk) disable iff (rst)
    (hen_n == 2'b11) |=> (doe == 2'b00 && dout == 32'h0));
  // R10
  a_r10_unselected: assert property (@(posedge clk) disable iff (rst)
    (sel_n || !sel) |=> (doe == 2'b00));
endmodule

bind hwsram_top hwsram_chk u_chk (
  .clk(clk), .rst(rst), .sel_n(sel_n), .sel(sel), .we_n(we_n),
  .oe_n(oe_n), .hen_n(hen_n), .dout(dout), .doe(doe)
);

// File: tb/hwsram_top_tb.sv
module hwsram_top_tb;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sel_n = 1'b1, sel = 1'b0, we_n = 1'b1, oe_n = 1'b1;
  logic [1:0]    hen_n = 2'b11;
  logic [AW-1:0] addr = '0;
  logic [31:0]   din = '0;
  logic [31:0]   dout;
  logic [1:0]    doe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [AW-1:0] A1 = 10, A2 = 20, A3 = 30, A4 = 40;
  logic [31:0] ref_mem [4];

  always #4 clk = ~clk;

  hwsram_top #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .sel_n(sel_n), .sel(sel), .we_n(we_n),
    .oe_n(oe_n), .hen_n(hen_n), .addr(addr), .din(din),
    .dout(dout), .doe(doe)
  );

  task automatic check(input string tag, input logic [1:0] exp_oe,
                       input logic [31:0] exp_d);
    checks++;
    if (doe !== exp_oe || dout !== exp_d) begin
      errors++;
      $display("FAIL %s: got doe=%b dout=%h, expected doe=%b dout=%h",
               tag, doe, dout, exp_oe, exp_d);
    end
  endtask

  task automatic go_idle();
    sel_n = 1'b1; sel = 1'b0; we_n = 1'b1; oe_n = 1'b1; hen_n = 2'b11;
  endtask

  // endm: 0 strobe rises, 1 sel_n rises, 2 sel falls
  task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d,
                          input logic [1:0] hen, input int endm,
                          input logic oe);
    @(negedge clk);
    sel_n = 1'b0; sel = 1'b1; we_n = 1'b0; oe_n = oe; hen_n = hen;
    addr = a; din = d;
    @(negedge clk);
    check("R6 no drive during write", 2'b00, 32'h0);
    din = ~d; addr = a ^ 1; hen_n = 2'b00;
    case (endm)
      0: we_n = 1'b1;
      1: sel_n = 1'b1;
      default: sel = 1'b0;
    endcase
    @(negedge clk);
    go_idle();
  endtask

  task automatic read_chk(input string tag, input logic [AW-1:0] a,
                          input logic [1:0] hen, input logic [1:0] exp_oe,
                          input logic [31:0] exp_d);
    @(negedge clk);
    sel_n = 1'b0; sel = 1'b1; we_n = 1'b1; oe_n = 1'b0; hen_n = hen; addr = a;
    @(negedge clk);
    check(tag, exp_oe, exp_d);
    go_idle();
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", 2'b00, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", 2'b00, 32'h0);
  endtask

  task automatic t_write_ends();
    do_write(A1, 32'hCAFE_1234, 2'b00, 0, 1'b0); ref_mem[0] = 32'hCAFE_1234;
    read_chk("R4 strobe-ended write", A1, 2'b00, 2'b11, ref_mem[0]);
    do_write(A2, 32'h0BAD_F00D, 2'b00, 1, 1'b0); ref_mem[1] = 32'h0BAD_F00D;
    read_chk("R5 sel_n-ended write", A2, 2'b00, 2'b11, ref_mem[1]);
    do_write(A3, 32'h5A5A_A5A5, 2'b00, 2, 1'b0); ref_mem[2] = 32'h5A5A_A5A5;
    read_chk("R5 sel-ended write", A3, 2'b00, 2'b11, ref_mem[2]);
    do_write(A4, 32'h7777_0001, 2'b00, 0, 1'b1); ref_mem[3] = 32'h7777_0001;
    read_chk("R6 write with oe_n high", A4, 2'b00, 2'b11, ref_mem[3]);
    read_chk("R2 full read", A1, 2'b00, 2'b11, ref_mem[0]);
  endtask

  task automatic t_addr_follow();
    @(negedge clk);
    sel_n = 1'b0; sel = 1'b1; we_n = 1'b1; oe_n = 1'b0; hen_n = 2'b00;
    addr = A1;
    for (int i = 1; i < 4; i++) begin
      @(negedge clk);
      check("R3 address follow", 2'b11, ref_mem[i-1]);
      addr = (i == 1) ? A2 : (i == 2) ? A3 : A4;
    end
    @(negedge clk);
    check("R3 address follow", 2'b11, ref_mem[3]);
    go_idle();
  endtask

  task automatic t_halves();
    do_write(A1, 32'h1111_2222, 2'b01, 0, 1'b0);
    ref_mem[0] = {16'h1111, ref_mem[0][15:0]};
    read_chk("R8 upper write, full read", A1, 2'b00, 2'b11, ref_mem[0]);
    read_chk("R8 upper-only read", A1, 2'b01, 2'b10, {ref_mem[0][31:16], 16'h0});
    read_chk("R8 lower-only read", A1, 2'b10, 2'b01, {16'h0, ref_mem[0][15:0]});
    do_write(A2, 32'h3333_4444, 2'b10, 1, 1'b0);
    ref_mem[1] = {ref_mem[1][31:16], 16'h4444};
    read_chk("R8 lower write, full read", A2, 2'b00, 2'b11, ref_mem[1]);
  endtask

  task automatic t_blocked();
    do_write(A3, 32'hDEAD_BEEF, 2'b11, 0, 1'b0);
    read_chk("R9 write with no half", A3, 2'b00, 2'b11, ref_mem[2]);
    read_chk("R9 read with no half", A3, 2'b11, 2'b00, 32'h0);
    // unselected writes
    @(negedge clk);
    sel_n = 1'b1; sel = 1'b1; we_n = 1'b0; oe_n = 1'b0; hen_n = 2'b00;
    addr = A4; din = 32'hFFFF_FFFF;
    @(negedge clk);
    check("R10 sel_n high, no drive", 2'b00, 32'h0);
    sel_n = 1'b0; sel = 1'b0;
    @(negedge clk);
    check("R10 sel low, no drive", 2'b00, 32'h0);
    we_n = 1'b1;
    @(negedge clk);
    go_idle();
    read_chk("R10 no store when unselected", A4, 2'b00, 2'b11, ref_mem[3]);
  endtask

  task automatic t_hiz();
    @(negedge clk);
    sel_n = 1'b0; sel = 1'b1; we_n = 1'b1; oe_n = 1'b1; hen_n = 2'b00; addr = A1;
    @(negedge clk);
    check("R7 oe_n high", 2'b00, 32'h0);
    oe_n = 1'b0;
    @(negedge clk);
    check("R7 oe_n low again", 2'b11, ref_mem[0]);
    go_idle();
  endtask

  initial begin
    t_reset();
    t_write_ends();
    t_addr_follow();
    t_halves();
    t_blocked();
    t_hiz();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule